// File: doc/BRIEF.md
# Timed pattern validator

The validator watches a stream of fixed-width words qualified by a valid strobe. It accepts a stored sequence of data words, and between consecutive words the stream must stay idle for an exact number of clock cycles. Two independent checkers run side by side. One compares each word with the stored value for its position. The other counts the idle cycles before every word after the first. The block raises a one-cycle pass pulse only when both checkers agree on the whole sequence. In every other case it raises a one-cycle fail pulse once the sequence has ended.

The block sits behind a steering switch that feeds it only when enabled. While the enable is low, the validator ignores the stream and stays armed for a fresh sequence. The stored words, the sequence length and the gap length are elaboration parameters. With the defaults, the sequence is four 8-bit words (0x99, 0xB9, 0xF9, 0xFB), each followed by an 8-cycle gap except the last.

Top module: `tpv_validator`

## Requirements
- R1: After reset, pass_o and fail_o are both low.
- R2: With en_i high, the four words 0x99, 0xB9, 0xF9, 0xFB in that order, with exactly 8 cycles of valid_i low between consecutive words, produce pass_o high for exactly one cycle. That cycle is the one right after the clock edge that samples the fourth word. fail_o stays low.
- R3: If any word differs from the stored word for its position while all gaps are correct, fail_o pulses for one cycle in the cycle after the fourth word, and pass_o stays low.
- R4: A gap shorter than 8 cycles causes the same fail outcome as R3. This includes a word that arrives while a gap is still running, even with no idle cycle at all.
- R5: A gap longer than 8 cycles causes the same fail outcome as R3.
- R6: After an error the block keeps consuming words until the fourth word and then gives its verdict. The next sequence is judged from scratch.
- R7: While en_i is low, valid_i and data_i are ignored and no pulse is produced. Dropping en_i mid-sequence discards all progress, so the next sequence starts again at its first word.
- R8: Idle cycles before the first word of a sequence are not timed. Any number of them is allowed.
- R9: pass_o and fail_o are never high in the same cycle, and neither is high in two consecutive cycles.
- R10: A verdict appears only after the fourth word of a sequence. Three words followed by silence give no pulse, and the pending fourth word is still judged when it comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable from the steering switch |
| data_i | input | 8 | Incoming word |
| valid_i | input | 1 | Qualifies data_i |
| pass_o | output | 1 | One-cycle pulse on an accepted sequence |
| fail_o | output | 1 | One-cycle pulse on a rejected sequence |

## Verification
The hardest situation to reach is a sequence that is half consumed when something breaks it: a sticky error that must survive the remaining words, an enable drop partway through, or a sequence left hanging after three words. The stimulus builds each case from word-and-gap primitives. It then follows the broken sequence directly with a clean one, or with the single missing word. The pulse that results, and its cycle, reveal whether position and error state were kept or cleared. Gaps of 0, 7, 8 and 9 cycles are placed in different slots so that each boundary of the timing path is exercised.

// File: rtl/tpv_pkg.sv
package tpv_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/tpv_seq_ctrl.sv
module tpv_seq_ctrl #(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (!en_i)    idx_q <= '0;
    else if (valid_i)  idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
  end

  assign idx_o   = idx_q;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST_IDX);

  // R10
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);

  // R7
  idx_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> idx_q == '0);
endmodule

// File: rtl/tpv_data_chk.sv
module tpv_data_chk #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 4,
  parameter logic [NUM_WORDS*WORD_W-1:0] KEY_WORDS = '0,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              last_i,
  output logic              data_ok_o
);
  logic [WORD_W-1:0] key_arr [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_key
    assign key_arr[k] = KEY_WORDS[k*WORD_W +: WORD_W];
  end

  logic match;
  logic err_q;
  logic accept;

  assign accept = en_i & valid_i;
  assign match  = (data_i == key_arr[idx_i]);

  // sticky until the sequence ends or the enable drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (!en_i)   err_q <= 1'b0;
    else if (accept)  err_q <= last_i ? 1'b0 : (err_q | ~match);
  end

  assign data_ok_o = ~err_q & match;

  // R6
  data_err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last_i) |=> !err_q);

  // R3
  data_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && en_i && !(valid_i && last_i)) |=> err_q);
endmodule

// File: rtl/tpv_gap_chk.sv
module tpv_gap_chk #(
  parameter int GAP_CYCLES = 8,
  localparam int CNT_W = $clog2(GAP_CYCLES + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic valid_i,
  input  logic first_i,
  input  logic last_i,
  output logic gap_ok_o
);
  localparam logic [CNT_W-1:0] GAP_VAL = CNT_W'(GAP_CYCLES);
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(GAP_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             terr_q;
  logic             hit;
  logic             accept;

  assign accept = en_i & valid_i;
  assign hit    = first_i | (cnt_q == GAP_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      terr_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      terr_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q  <= '0;
      terr_q <= last_i ? 1'b0 : (terr_q | ~hit);
    end else if (cnt_q != SAT_VAL) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign gap_ok_o = ~terr_q & hit;

  // R5
  gap_cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT_VAL);

  // R4
  gap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> cnt_q == '0);

  // R6
  gap_err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && last_i) |=> !terr_q);
endmodule

// File: rtl/tpv_validator.sv
module tpv_validator #(
  parameter int WORD_W     = 8,
  parameter int NUM_WORDS  = 4,
  parameter int GAP_CYCLES = 8,
  parameter logic [NUM_WORDS*WORD_W-1:0] KEY_WORDS = 32'hFBF9_B999
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              pass_o,
  output logic              fail_o
);
  import tpv_pkg::*;

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [IDX_W-1:0] idx;
  logic             first_w;
  logic             last_w;
  logic             data_ok;
  logic             gap_ok;
  logic             accept;
  verdict_e         res_q;

  assign accept = en_i & valid_i;

  tpv_seq_ctrl #(.NUM_WORDS(NUM_WORDS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .valid_i (valid_i),
    .idx_o   (idx),
    .first_o (first_w),
    .last_o  (last_w)
  );

  tpv_data_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .KEY_WORDS (KEY_WORDS)
  ) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .valid_i   (valid_i),
    .data_i    (data_i),
    .idx_i     (idx),
    .last_i    (last_w),
    .data_ok_o (data_ok)
  );

  tpv_gap_chk #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valid_i  (valid_i),
    .first_i  (first_w),
    .last_i   (last_w),
    .gap_ok_o (gap_ok)
  );

  // both paths must agree on the final word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                res_q <= VERDICT_NONE;
    else if (accept && last_w)  res_q <= (data_ok && gap_ok) ? VERDICT_PASS : VERDICT_FAIL;
    else                        res_q <= VERDICT_NONE;
  end

  assign pass_o = (res_q == VERDICT_PASS);
  assign fail_o = (res_q == VERDICT_FAIL);

  // R9
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  // R9
  pass_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);

  // R9
  fail_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);

  // R10
  verdict_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> $past(valid_i && en_i && last_w));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pass_o && !fail_o);
endmodule

// File: tb/tpv_validator_bench.sv
module tpv_validator_bench;
  localparam logic [31:0] GOOD = 32'hFBF9_B999;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       pass_w;
  logic       fail_w;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int npulse = 0;
  bit done = 0;
  bit mon_on = 0;

  bit    kq[$];
  int    cq[$];
  string tq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tpv_validator u_tpv_validator (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .data_i  (data),
    .valid_i (valid),
    .pass_o  (pass_w),
    .fail_o  (fail_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic word(input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1;
    data  = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      data  = 8'h00;
    end
  endtask

  task automatic expect_verdict(input bit is_pass, input string tag);
    kq.push_back(is_pass);
    cq.push_back(cyc + 1);
    tq.push_back(tag);
  endtask

  task automatic send_seq(input logic [31:0] w, input int g0, input int g1, input int g2,
                          input bit is_pass, input string tag);
    word(w[7:0]);   idle(g0);
    word(w[15:8]);  idle(g1);
    word(w[23:16]); idle(g2);
    word(w[31:24]);
    expect_verdict(is_pass, tag);
    idle(4);
  endtask

  // monitor: pops the scoreboard when a pulse appears
  always @(negedge clk) begin
    if (mon_on) begin
      if (pass_w && fail_w) chk(1'b0, "R9 both pulses high", 1, 0);
      if (pass_w || fail_w) begin
        npulse++;
        if (kq.size() == 0) begin
          chk(1'b0, "R10 unexpected pulse", int'(pass_w), 0);
        end else begin
          chk(kq[0] == pass_w && cq[0] == cyc, tq[0], cyc * 2 + int'(pass_w),
              cq[0] * 2 + int'(kq[0]));
          void'(kq.pop_front()); void'(cq.pop_front()); void'(tq.pop_front());
        end
      end else if (cq.size() != 0 && cq[0] <= cyc) begin
        chk(1'b0, {tq[0], " missing pulse"}, 0, 1);
        void'(kq.pop_front()); void'(cq.pop_front()); void'(tq.pop_front());
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk(!pass_w, "R1 pass low in reset", int'(pass_w), 0);
    chk(!fail_w, "R1 fail low in reset", int'(fail_w), 0);
    rst_n = 1'b1;
    idle(2);
    chk(!pass_w && !fail_w, "R1 outputs low after reset", int'(pass_w | fail_w), 0);
    mon_on = 1;
    en = 1'b1;
    idle(2);

    send_seq(GOOD, 8, 8, 8, 1'b1, "R2 correct sequence");
    send_seq(32'hFBF9_B899, 8, 8, 8, 1'b0, "R3 second word wrong");
    send_seq(32'hFAF9_B999, 8, 8, 8, 1'b0, "R3 last word wrong");
    send_seq(GOOD, 8, 7, 8, 1'b0, "R4 gap of 7");
    send_seq(GOOD, 0, 8, 8, 1'b0, "R4 word during gap");
    send_seq(GOOD, 8, 8, 9, 1'b0, "R5 gap of 9");
    send_seq(32'hFBF9_B998, 8, 8, 8, 1'b0, "R6 first word wrong");
    send_seq(GOOD, 8, 8, 8, 1'b1, "R6 fresh after error");
    send_seq(GOOD, 7, 9, 8, 1'b0, "R6 two timing errors");
    send_seq(GOOD, 8, 8, 8, 1'b1, "R6 fresh after timing error");

    idle(100);
    send_seq(GOOD, 8, 8, 8, 1'b1, "R8 long idle before first word");

    // R7: stream ignored while disabled
    en = 1'b0;
    p0 = npulse;
    word(8'h99); idle(8); word(8'hB9); idle(8); word(8'hF9); idle(8); word(8'hFB);
    idle(6);
    chk(npulse == p0, "R7 no pulse while disabled", npulse - p0, 0);
    en = 1'b1;
    idle(2);
    send_seq(GOOD, 8, 8, 8, 1'b1, "R7 fresh after disabled stream");

    // R7: drop enable mid-sequence
    word(8'h99); idle(8); word(8'hB9); idle(3);
    en = 1'b0;
    idle(2);
    en = 1'b1;
    idle(2);
    send_seq(GOOD, 8, 8, 8, 1'b1, "R7 progress discarded on enable drop");

    // R10: three words, silence, then the pending last word
    p0 = npulse;
    word(8'h99); idle(8); word(8'hB9); idle(8); word(8'hF9); idle(40);
    chk(npulse == p0, "R10 no verdict after three words", npulse - p0, 0);
    word(8'hFB);
    expect_verdict(1'b0, "R10 pending last word judged");
    idle(4);
    send_seq(GOOD, 8, 8, 8, 1'b1, "R10 aligned after verdict");

    idle(6);
    chk(kq.size() == 0, "R9 scoreboard drained", kq.size(), 0);
    done = 1;
    report();
    $finish;
  end
endmodule